// File: doc/BRIEF.md
# Serial NOR Flash Range Erase Sequencer

This block is a master-side engine that clears a byte range of a serial NOR flash. A host hands it a start address, a length, the total device size, the erase granule size and the opcode that erases one granule. One pulse starts the request. The block checks the range first. A range that is out of bounds or not aligned to the granule is refused at once with an error and no flash traffic.

An accepted range is erased one granule at a time. Before every erase the block reads the flash status until the device reports idle. It then sends a write-enable frame and finally the erase frame. When the length covers the whole device, a single chip-wide erase frame replaces the per-granule loop. The block gives up with an error if the device stays busy for too many status reads in a row.

The SPI bit shifter is outside the block. The block reaches it through a byte handshake. A chip-select level marks each frame. A request line with a data byte asks for one full-duplex byte exchange. The shifter answers with a one-cycle acknowledge carrying the byte it received.

Top module: `snor_erase_seq`

## Requirements
- R1: A request whose start address plus length is greater than the device size ends with `done` and `err` both high one cycle after the start pulse, and no frame is sent. A range ending exactly at the device size is accepted.
- R2: A request whose start address or length is not a multiple of the granule size, or whose granule size is zero or not a power of two, is refused the same way as in R1.
- R3: Before every erase frame, the block sends status frames of two bytes each: 0x05, then a filler byte 0x00. The byte received during the filler is the status, and bit 0 set means the device is busy. Status frames repeat until bit 0 reads clear.
- R4: After `POLL_LIMIT` (default 100000) status reads in a row that all show busy, the block ends with `done` and `err` high, and no write-enable or erase frame follows.
- R5: Every erase frame comes right after a single-byte write-enable frame carrying 0x06, which itself follows a status read that showed idle.
- R6: When the length is non-zero and equals the device size, the block sends exactly one erase frame, and that frame is the single byte 0xC7.
- R7: In every other accepted case, each erase frame is four bytes. The first byte is the requested erase opcode (for example 0x20 for 4 KiB or 0xD8 for a large sector). The next three bytes are the 24-bit address, most significant byte first. The address starts at the start address and grows by the granule size from one frame to the next, until the length is used up.
- R8: `spi_cs` is high for the whole of each frame, and `spi_req` is only high while `spi_cs` is high. `spi_cs` drops between any two frames, including between the write-enable frame and the erase frame.
- R9: `done` is a one-cycle pulse, and `err` is valid in that cycle. `busy` is high from the cycle after an accepted start until the cycle in which `done` rises. A zero length is accepted: it ends with `done` and no error, and no frame is sent.
- R10: A start pulse while `busy` is high is ignored. The running request's frames are unchanged, and exactly one `done` pulse follows.
- R11: After reset, `busy`, `done`, `spi_cs` and `spi_req` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request pulse |
| req_addr | input | AW | First byte address of the range |
| req_len | input | AW+1 | Range length in bytes |
| dev_size | input | AW+1 | Total device size in bytes |
| gran_size | input | AW+1 | Erase granule size in bytes (power of two) |
| erase_op | input | 8 | Opcode used for one granule erase |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with `done` |
| spi_cs | output | 1 | Frame select, high for the length of a frame |
| spi_req | output | 1 | Byte exchange request |
| spi_wdata | output | 8 | Byte to shift out |
| spi_ack | input | 1 | One-cycle acknowledge from the shifter |
| spi_rdata | input | 8 | Byte shifted in, valid with `spi_ack` |

## Verification
The assertions take three things for granted about the inputs. The shifter acknowledges only while a byte request is pending, and never twice for the same byte. The request fields are stable in the cycle of the start pulse. The device size never exceeds the 24-bit address space. The bench's flash model raises `spi_ack` one cycle after it sees `spi_req`, and drops it the next cycle. It drives all request fields together with `start` on the falling edge. It keeps every device size within 16 MiB. In the busy-start test it changes the request fields while the sequencer works, so the assertion on the latched fields is actually exercised.

// File: rtl/snor_pkg.sv
package snor_pkg;
   localparam logic [7:0] OPC_STATUS = 8'h05;
   localparam logic [7:0] OPC_WREN   = 8'h06;
   localparam logic [7:0] OPC_CHIP   = 8'hC7;
   localparam logic [7:0] FILL_BYTE  = 8'h00;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_POLL, SQ_POLL_W, SQ_WEN, SQ_WEN_W, SQ_ERS, SQ_ERS_W
   } seq_state_e;

   typedef enum logic [1:0] {
      FR_IDLE, FR_SETUP, FR_SEND, FR_REL
   } frame_state_e;
endpackage

// File: rtl/snor_range_check.sv
module snor_range_check #(
   parameter int AW = 24
) (
   input  logic [AW-1:0] addr,
   input  logic [AW:0]   len,
   input  logic [AW:0]   dev,
   input  logic [AW:0]   gran,
   output logic          ok,
   output logic          chip,
   output logic          empty
);
   localparam int LW = AW + 1;

   logic [LW:0]   end_sum;
   logic [LW-1:0] gmask;
   logic [LW-1:0] addr_ext;
   logic          pow2;
   logic          in_bounds;
   logic          aligned;

   always_comb begin
      addr_ext  = {1'b0, addr};
      end_sum   = {1'b0, addr_ext} + {1'b0, len};
      gmask     = gran - 1'b1;
      pow2      = (gran != '0) && ((gran & gmask) == '0);
      in_bounds = end_sum <= {1'b0, dev};
      aligned   = ((addr_ext & gmask) == '0) && ((len & gmask) == '0);
      ok        = pow2 && in_bounds && aligned;
      empty     = (len == '0);
      chip      = (len == dev) && !empty;
   end
endmodule

// File: rtl/snor_poll_budget.sv
module snor_poll_budget #(
   parameter int LIMIT = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bump,
   output logic last
);
   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("snor_poll_budget: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (bump) cnt <= cnt + 1'b1;
   end

   assign last = (cnt == CW'(LIMIT - 1));

   // R4: the busy-read count never passes the limit
   assert_budget_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt <= CW'(LIMIT - 1)));

   // R4: no increment once the final read is reached
   assert_no_bump_at_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !clr) |=> $stable(cnt));
endmodule

// File: rtl/snor_frame.sv
module snor_frame
   import snor_pkg::*;
#(
   parameter int MAXB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [$clog2(MAXB):0] n_bytes,
   input  logic [MAXB*8-1:0] frame_bytes,
   output logic              cs,
   output logic              req,
   output logic [7:0]        wdata,
   input  logic              ack,
   input  logic [7:0]        rdata,
   output logic              fin,
   output logic [7:0]        rx_last
);
   localparam int IW = $clog2(MAXB);

   generate
      if (MAXB < 2) begin : g_bad_maxb
         $error("snor_frame: MAXB must be at least 2");
      end
   endgenerate

   frame_state_e      st;
   logic [MAXB*8-1:0] buf_q;
   logic [IW:0]       n_q;
   logic [IW-1:0]     idx;
   logic [7:0]        rx_q;
   logic [7:0]        byte_v [MAXB];

   genvar gi;
   generate
      for (gi = 0; gi < MAXB; gi++) begin : g_byte
         assign byte_v[gi] = buf_q[gi*8 +: 8];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= FR_IDLE;
         buf_q <= '0;
         n_q   <= '0;
         idx   <= '0;
         rx_q  <= '0;
      end else begin
         case (st)
            FR_IDLE: if (go) begin
               buf_q <= frame_bytes;
               n_q   <= n_bytes;
               idx   <= '0;
               st    <= FR_SETUP;
            end
            FR_SETUP: st <= FR_SEND;
            FR_SEND: if (ack) begin
               rx_q <= rdata;
               if ({1'b0, idx} == n_q - 1'b1) st <= FR_REL;
               else                           idx <= idx + 1'b1;
            end
            default: st <= FR_IDLE;
         endcase
      end
   end

   assign cs      = (st == FR_SETUP) || (st == FR_SEND);
   assign req     = (st == FR_SEND);
   assign wdata   = byte_v[idx];
   assign fin     = (st == FR_REL);
   assign rx_last = rx_q;

   // R8: a byte request only inside a selected frame
   assert_req_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> cs);

   // R8: select stays low at least one cycle after a frame ends
   assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs) |=> !cs);

   // R8: a new frame is launched only when the framer is free
   assert_go_when_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (st == FR_IDLE));
endmodule

// File: rtl/snor_erase_seq.sv
module snor_erase_seq
   import snor_pkg::*;
#(
   parameter int AW         = 24,
   parameter int POLL_LIMIT = 100000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] req_addr,
   input  logic [AW:0]   req_len,
   input  logic [AW:0]   dev_size,
   input  logic [AW:0]   gran_size,
   input  logic [7:0]    erase_op,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic          spi_cs,
   output logic          spi_req,
   output logic [7:0]    spi_wdata,
   input  logic          spi_ack,
   input  logic [7:0]    spi_rdata
);
   localparam int MAXB = 4;
   localparam int NBW  = $clog2(MAXB) + 1;

   generate
      if (AW < 8 || AW > 24) begin : g_bad_aw
         $error("snor_erase_seq: AW must lie in 8..24");
      end
   endgenerate

   seq_state_e      state;
   logic [AW-1:0]   addr_q;
   logic [AW:0]     remain_q;
   logic [AW:0]     gran_q;
   logic [7:0]      op_q;
   logic            chip_q;
   logic            done_q;
   logic            err_q;
   logic            wen_seen;
   logic [23:0]     addr24;

   logic            rc_ok, rc_chip, rc_empty;
   logic            fr_go, fr_fin;
   logic [7:0]      fr_rx;
   logic [NBW-1:0]  fr_n;
   logic [MAXB*8-1:0] fr_bytes;
   logic            bud_clr, bud_bump, bud_last;

   generate
      if (AW == 24) begin : g_addr_full
         assign addr24 = addr_q;
      end else begin : g_addr_pad
         assign addr24 = {{(24 - AW){1'b0}}, addr_q};
      end
   endgenerate

   snor_range_check #(.AW(AW)) u_check (
      .addr  (req_addr),
      .len   (req_len),
      .dev   (dev_size),
      .gran  (gran_size),
      .ok    (rc_ok),
      .chip  (rc_chip),
      .empty (rc_empty)
   );

   snor_poll_budget #(.LIMIT(POLL_LIMIT)) u_budget (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (bud_clr),
      .bump  (bud_bump),
      .last  (bud_last)
   );

   always_comb begin
      fr_go    = (state == SQ_POLL) || (state == SQ_WEN) || (state == SQ_ERS);
      fr_n     = NBW'(1);
      fr_bytes = '0;
      case (state)
         SQ_POLL: begin
            fr_n     = NBW'(2);
            fr_bytes = {16'h0000, FILL_BYTE, OPC_STATUS};
         end
         SQ_WEN: begin
            fr_n     = NBW'(1);
            fr_bytes = {24'h000000, OPC_WREN};
         end
         SQ_ERS: begin
            if (chip_q) begin
               fr_n     = NBW'(1);
               fr_bytes = {24'h000000, OPC_CHIP};
            end else begin
               fr_n     = NBW'(4);
               fr_bytes = {addr24[7:0], addr24[15:8], addr24[23:16], op_q};
            end
         end
         default: ;
      endcase
   end

   snor_frame #(.MAXB(MAXB)) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (fr_go),
      .n_bytes     (fr_n),
      .frame_bytes (fr_bytes),
      .cs          (spi_cs),
      .req         (spi_req),
      .wdata       (spi_wdata),
      .ack         (spi_ack),
      .rdata       (spi_rdata),
      .fin         (fr_fin),
      .rx_last     (fr_rx)
   );

   assign bud_clr  = (state == SQ_IDLE) || (state == SQ_ERS_W);
   assign bud_bump = (state == SQ_POLL_W) && fr_fin && fr_rx[0] && !bud_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         addr_q   <= '0;
         remain_q <= '0;
         gran_q   <= '0;
         op_q     <= '0;
         chip_q   <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         wen_seen <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            SQ_IDLE: if (start) begin
               err_q <= 1'b0;
               if (!rc_ok) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
               end else if (rc_empty) begin
                  done_q <= 1'b1;
               end else begin
                  addr_q   <= req_addr;
                  remain_q <= req_len;
                  gran_q   <= gran_size;
                  op_q     <= erase_op;
                  chip_q   <= rc_chip;
                  state    <= SQ_POLL;
               end
            end
            SQ_POLL: state <= SQ_POLL_W;
            SQ_POLL_W: if (fr_fin) begin
               if (!fr_rx[0]) begin
                  state <= SQ_WEN;
               end else if (bud_last) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
                  state  <= SQ_IDLE;
               end else begin
                  state <= SQ_POLL;
               end
            end
            SQ_WEN: state <= SQ_WEN_W;
            SQ_WEN_W: if (fr_fin) begin
               wen_seen <= 1'b1;
               state    <= SQ_ERS;
            end
            SQ_ERS: begin
               wen_seen <= 1'b0;
               state    <= SQ_ERS_W;
            end
            SQ_ERS_W: if (fr_fin) begin
               if (chip_q || (remain_q == gran_q)) begin
                  done_q <= 1'b1;
                  state  <= SQ_IDLE;
               end else begin
                  addr_q   <= addr_q + gran_q[AW-1:0];
                  remain_q <= remain_q - gran_q;
                  state    <= SQ_POLL;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign busy = (state != SQ_IDLE);
   assign done = done_q;
   assign err  = err_q;

   // R1: a refused range completes with an error on the next cycle
   assert_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !rc_ok) |=> (done && err));

   // R2: a refused range never opens a frame
   assert_no_frame_on_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !rc_ok) |=> !spi_cs);

   // R5: the erase frame launches only after a completed write-enable frame
   assert_wren_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_ERS) |-> wen_seen);

   // R6: a chip-wide erase ends the request after its single frame
   assert_chip_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == SQ_ERS_W) && fr_fin && chip_q) |=> (!busy && done));

   // R9: completion is a single-cycle pulse
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: frames only occur while a request is in progress
   assert_cs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs |-> busy);

   // R10: a start during a request leaves the latched request alone
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(gran_q) && $stable(op_q) && $stable(chip_q)));
endmodule

// File: tb/snor_erase_seq_test.sv
module snor_erase_seq_test;
   localparam int AW    = 24;
   localparam int LIMIT = 6;

   typedef struct packed {
      logic [23:0] addr;
      logic [24:0] len;
      logic [24:0] dev;
      logic [24:0] gran;
      logic [7:0]  op;
      logic [7:0]  nbusy;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{24'h001000, 25'h0002000, 25'h0010000, 25'h0001000, 8'h20, 8'd2},
      '{24'h000000, 25'h0010000, 25'h0010000, 25'h0001000, 8'h20, 8'd1},
      '{24'h00F000, 25'h0002000, 25'h0010000, 25'h0001000, 8'h20, 8'd0},
      '{24'h000800, 25'h0001000, 25'h0010000, 25'h0001000, 8'h20, 8'd0},
      '{24'h001000, 25'h0000800, 25'h0010000, 25'h0001000, 8'h20, 8'd0},
      '{24'h010000, 25'h0020000, 25'h0040000, 25'h0010000, 8'hD8, 8'd0},
      '{24'hABC000, 25'h0003000, 25'h1000000, 25'h0001000, 8'h20, 8'd3},
      '{24'h000000, 25'h0001000, 25'h0010000, 25'h0001000, 8'h20, 8'd200},
      '{24'h004000, 25'h0000000, 25'h0010000, 25'h0001000, 8'h20, 8'd0},
      '{24'h008000, 25'h0008000, 25'h0010000, 25'h0001000, 8'h20, 8'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [AW:0]   req_len = '0;
   logic [AW:0]   dev_size = '0;
   logic [AW:0]   gran_size = '0;
   logic [7:0]    erase_op = '0;
   logic          busy, done, err, spi_cs, spi_req;
   logic [7:0]    spi_wdata;
   logic          spi_ack = 1'b0;
   logic [7:0]    spi_rdata = '0;

   always #2 clk = ~clk;

   snor_erase_seq #(.AW(AW), .POLL_LIMIT(LIMIT)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
      .req_len(req_len), .dev_size(dev_size), .gran_size(gran_size),
      .erase_op(erase_op), .busy(busy), .done(done), .err(err),
      .spi_cs(spi_cs), .spi_req(spi_req), .spi_wdata(spi_wdata),
      .spi_ack(spi_ack), .spi_rdata(spi_rdata)
   );

   int errors = 0;
   int checks = 0;

   // flash model and frame recorder
   int          busy_left = 0;
   int          busy_reload = 0;
   logic        prev_cs = 1'b0;
   logic [31:0] cur_w = '0;
   int          cur_n = 0;
   logic [31:0] rec_w [64];
   int          rec_b [64];
   int          rec_n = 0;
   int          req_out_cs = 0;
   int          done_cnt = 0;
   int          cycles = 0;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      prev_cs <= spi_cs;
      if (done) done_cnt = done_cnt + 1;
      if (spi_req && !spi_cs) req_out_cs = req_out_cs + 1;
      if (spi_cs && !prev_cs) begin
         cur_w = '0;
         cur_n = 0;
      end
      if (spi_req && !spi_ack) begin
         spi_ack <= 1'b1;
         if (cur_n == 1 && cur_w[7:0] == 8'h05) begin
            spi_rdata <= {7'b0, busy_left != 0};
            if (busy_left != 0) busy_left = busy_left - 1;
         end else begin
            spi_rdata <= 8'h00;
         end
         cur_w = (cur_w << 8) | {24'h0, spi_wdata};
         cur_n = cur_n + 1;
      end else begin
         spi_ack <= 1'b0;
      end
      if (!spi_cs && prev_cs) begin
         if (rec_n < 64) begin
            rec_w[rec_n] = cur_w;
            rec_b[rec_n] = cur_n;
         end
         rec_n = rec_n + 1;
         if (cur_n == 4 || (cur_n == 1 && cur_w[7:0] == 8'hC7)) busy_left = busy_reload;
      end
   end

   always @(posedge clk) begin
      if (cycles > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // expected frames computed from the requirements
   logic [31:0] exp_w [64];
   int          exp_b [64];
   int          exp_n;
   bit          exp_err;

   task automatic push_exp(input logic [31:0] w, input int b);
      if (exp_n < 64) begin
         exp_w[exp_n] = w;
         exp_b[exp_n] = b;
      end
      exp_n = exp_n + 1;
   endtask

   task automatic build_exp(input vec_t v);
      longint a, l, d, g, units, cur;
      bit bad;
      a = longint'(v.addr); l = longint'(v.len); d = longint'(v.dev); g = longint'(v.gran);
      exp_n = 0;
      exp_err = 1'b0;
      bad = (g == 0) || ((g & (g - 1)) != 0) || (a + l > d) || (a % g != 0) || (l % g != 0);
      if (bad) begin
         exp_err = 1'b1;
         return;
      end
      if (l == 0) return;
      units = (l == d) ? 1 : l / g;
      cur = a;
      for (longint u = 0; u < units; u++) begin
         if (int'(v.nbusy) >= LIMIT) begin
            for (int p = 0; p < LIMIT; p++) push_exp(32'h0500, 2);
            exp_err = 1'b1;
            return;
         end
         for (int p = 0; p <= int'(v.nbusy); p++) push_exp(32'h0500, 2);
         push_exp(32'h06, 1);
         if (l == d) push_exp(32'hC7, 1);
         else        push_exp({v.op, cur[23:0]}, 4);
         cur = cur + g;
      end
   endtask

   task automatic run_req(input vec_t v, output bit got_err);
      @(negedge clk);
      rec_n = 0;
      busy_left = int'(v.nbusy);
      busy_reload = int'(v.nbusy);
      req_addr = v.addr; req_len = v.len; dev_size = v.dev;
      gran_size = v.gran; erase_op = v.op;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      got_err = err;
   endtask

   function automatic string tag_of(input int i);
      case (i)
         0: return "R7";
         1: return "R6";
         2: return "R1";
         3: return "R2";
         4: return "R2";
         5: return "R7";
         6: return "R3";
         7: return "R4";
         8: return "R9";
         default: return "R7";
      endcase
   endfunction

   task automatic cmp_frames(input string tag);
      int bad_i;
      bad_i = -1;
      chk(rec_n == exp_n, tag, "frame count", rec_n, exp_n);
      for (int k = 0; k < exp_n && k < rec_n && k < 64; k++)
         if (bad_i < 0 && (rec_w[k] != exp_w[k] || rec_b[k] != exp_b[k])) bad_i = k;
      if (bad_i >= 0) chk(1'b0, tag, "frame content", rec_w[bad_i], exp_w[bad_i]);
      else            chk(1'b1, tag, "frame content", 0, 0);
   endtask

   initial begin
      bit e;
      int d0;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(!busy && !done && !spi_cs && !spi_req, "R11", "reset outputs",
          {busy, done, spi_cs, spi_req}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         build_exp(VECS[i]);
         run_req(VECS[i], e);
         chk(e == exp_err, tag_of(i), "error flag", e, exp_err);
         cmp_frames(tag_of(i));
         repeat (3) @(negedge clk);
      end

      // R5: write-enable frame directly before each erase frame (vector 0)
      begin
         int miss;
         miss = 0;
         build_exp(VECS[0]);
         run_req(VECS[0], e);
         for (int k = 0; k < rec_n && k < 64; k++)
            if (rec_b[k] == 4 && (k < 2 || rec_w[k-1] != 32'h06 || rec_w[k-2] != 32'h0500)) miss++;
         chk(miss == 0, "R5", "write-enable precedes erase", miss, 0);
      end

      // R8: no byte request outside a frame over the whole run
      chk(req_out_cs == 0, "R8", "request outside select", req_out_cs, 0);

      // R9: busy timing and single done pulse
      build_exp(VECS[5]);
      @(negedge clk);
      rec_n = 0; busy_left = 0; busy_reload = 0;
      req_addr = VECS[5].addr; req_len = VECS[5].len; dev_size = VECS[5].dev;
      gran_size = VECS[5].gran; erase_op = VECS[5].op;
      start = 1'b1;
      chk(!busy, "R9", "busy before start", busy, 0);
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R9", "busy after accepted start", busy, 1);
      while (!done) @(negedge clk);
      chk(!busy && !err, "R9", "idle and no error with done", {busy, err}, 0);
      @(negedge clk);
      chk(!done, "R9", "done lasts one cycle", done, 0);

      // R10: start while busy is ignored
      build_exp(VECS[0]);
      d0 = done_cnt;
      @(negedge clk);
      rec_n = 0; busy_left = 2; busy_reload = 2;
      req_addr = VECS[0].addr; req_len = VECS[0].len; dev_size = VECS[0].dev;
      gran_size = VECS[0].gran; erase_op = VECS[0].op;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      req_addr = 24'h000000; req_len = 25'h0010000; erase_op = 8'hD8;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      e = err;
      repeat (60) @(negedge clk);
      chk(!e, "R10", "running request error flag", e, 0);
      cmp_frames("R10");
      chk(done_cnt - d0 == 1, "R10", "done pulses", done_cnt - d0, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule